// File: doc/BRIEF.md
# Half-duplex debug data transfer register

This block is the 64-bit data exchange register between a processor and an external debugger. It holds two 32-bit mailboxes, each with a full flag. The receive mailbox carries words from the debugger to the processor. The transmit mailbox carries words from the processor to the debugger.

The processor reaches both mailboxes through one 64-bit register. A processor write loads both words at once but raises only the transmit flag. A processor read returns both words with the transmit word in the upper half, and it drops only the receive flag. The debugger has a 32-bit write port into the receive mailbox and a 32-bit read port that shows the transmit mailbox.

A processor write made while the transmit mailbox is still full leaves both words unchanged and raises a clash strobe. A processor read made while the receive mailbox is empty returns zeros and raises an empty strobe.

Top module: `dbgx_dtr`

## Requirements
- R1: A low `rst_n` at a clock edge (synchronous reset) clears `rx_full`, `tx_full`, the receive word and the transmit word, so `dbg_tx_rd_data` reads 0 after reset.
- R2: A processor write with `tx_full` = 0 stores `cpu_wr_data[63:32]` in the receive word and `cpu_wr_data[31:0]` in the transmit word, and `tx_full` reads 1 after the edge.
- R3: A processor write with `tx_full` = 1 raises `cpu_wr_clash` in the same cycle and leaves both words unchanged.
- R4: A processor write never changes `rx_full`.
- R5: A processor read with `rx_full` = 1 drives `cpu_rd_data` in the same cycle, with the transmit word on bits [63:32] and the receive word on bits [31:0].
- R6: A processor read with `rx_full` = 0 drives `cpu_rd_data` to zero and raises `cpu_rd_empty` in the same cycle. `cpu_rd_data` is also zero whenever `cpu_rd_en` is low.
- R7: Any processor read clears `rx_full` at the following edge.
- R8: A debugger write loads `dbg_rx_wr_data` into the receive word and sets `rx_full`.
- R9: `dbg_tx_rd_data` always shows the transmit word. A debugger read (`dbg_tx_rd_en`) clears `tx_full`.
- R10: When processor and debugger updates fall in the same cycle, the processor update is applied first and the debugger update last. A read together with a debugger write leaves `rx_full` = 1 and the debugger's word stored. A processor write together with a debugger write keeps the debugger's receive word. A processor write together with a debugger read stores the new transmit word but leaves `tx_full` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_wr_data | input | 64 | Processor write data: upper half to the receive word, lower half to the transmit word |
| cpu_rd_en | input | 1 | Processor read strobe |
| cpu_rd_data | output | 64 | Processor read data: {transmit word, receive word} |
| cpu_rd_empty | output | 1 | Read made while the receive mailbox is empty |
| cpu_wr_clash | output | 1 | Write made while the transmit mailbox is full |
| dbg_rx_wr_en | input | 1 | Debugger write strobe into the receive mailbox |
| dbg_rx_wr_data | input | 32 | Debugger write data |
| dbg_tx_rd_en | input | 1 | Debugger read strobe (consumes the transmit word) |
| dbg_tx_rd_data | output | 32 | Current transmit word |
| rx_full | output | 1 | Receive mailbox full |
| tx_full | output | 1 | Transmit mailbox full |

## Verification
Each mailbox flag can be touched by both sides in the same cycle. The processor read races a debugger write on the receive flag, and a processor write races a debugger read on the transmit flag. The bench drives each pair in one cycle. It also drives a processor write and a debugger write together, which both load the receive word. A reference model applies the processor effect first and the debugger effect last. The flags, `dbg_tx_rd_data` and a later processor read are then compared with that model.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;
  localparam int unsigned DBGX_WORD_W = 32;

  // Flag update: processor action first, debugger action last.
  function automatic logic flag_next(input logic cur,
                                     input logic p_set, input logic p_clr,
                                     input logic d_set, input logic d_clr);
    logic f;
    f = cur;
    if (p_clr) f = 1'b0;
    if (p_set) f = 1'b1;
    if (d_clr) f = 1'b0;
    if (d_set) f = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/dbgx_slot.sv
module dbgx_slot #(
  parameter int unsigned W = dbgx_pkg::DBGX_WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         p_load,
  input  logic [W-1:0] p_data,
  input  logic         p_set,
  input  logic         p_clr,
  input  logic         d_load,
  input  logic [W-1:0] d_data,
  input  logic         d_set,
  input  logic         d_clr,
  output logic [W-1:0] word,
  output logic         full
);
  logic [W-1:0] word_nx;
  logic         full_nx;

  always_comb begin
    word_nx = word;
    if (p_load) word_nx = p_data;
    if (d_load) word_nx = d_data;
    full_nx = dbgx_pkg::flag_next(full, p_set, p_clr, d_set, d_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      full <= 1'b0;
    end else begin
      word <= word_nx;
      full <= full_nx;
    end
  end

  // R10: debugger action is applied last
  a_r10_dbg_set_last: assert property (@(posedge clk) disable iff (!rst_n)
    d_set |=> full);
  a_r10_dbg_clr_last: assert property (@(posedge clk) disable iff (!rst_n)
    (d_clr && !d_set) |=> !full);
  a_r10_dbg_word_last: assert property (@(posedge clk) disable iff (!rst_n)
    d_load |=> (word == $past(d_data)));
endmodule

// File: rtl/dbgx_rdmux.sv
module dbgx_rdmux #(
  parameter int unsigned W = dbgx_pkg::DBGX_WORD_W,
  localparam int unsigned DW = 2 * W
) (
  input  logic          rd_en,
  input  logic          have_rx,
  input  logic [W-1:0]  tx_word,
  input  logic [W-1:0]  rx_word,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  always_comb begin
    rd_empty = rd_en && !have_rx;
    rd_data  = (rd_en && have_rx) ? {tx_word, rx_word} : '0;
  end

  // R6: an empty read returns zero
  always_comb begin
    a_r6_empty_zero: assert (!rd_empty || rd_data == '0);
  end
endmodule

// File: rtl/dbgx_dtr.sv
module dbgx_dtr #(
  parameter int unsigned WORD_W = dbgx_pkg::DBGX_WORD_W,
  localparam int unsigned DTR_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [DTR_W-1:0]  cpu_wr_data,
  input  logic              cpu_rd_en,
  output logic [DTR_W-1:0]  cpu_rd_data,
  output logic              cpu_rd_empty,
  output logic              cpu_wr_clash,
  input  logic              dbg_rx_wr_en,
  input  logic [WORD_W-1:0] dbg_rx_wr_data,
  input  logic              dbg_tx_rd_en,
  output logic [WORD_W-1:0] dbg_tx_rd_data,
  output logic              rx_full,
  output logic              tx_full
);
  logic              wr_accept;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] tx_word;

  assign wr_accept    = cpu_wr_en && !tx_full;
  assign cpu_wr_clash = cpu_wr_en && tx_full;

  dbgx_slot #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .p_load(wr_accept), .p_data(cpu_wr_data[DTR_W-1:WORD_W]),
    .p_set(1'b0), .p_clr(cpu_rd_en),
    .d_load(dbg_rx_wr_en), .d_data(dbg_rx_wr_data),
    .d_set(dbg_rx_wr_en), .d_clr(1'b0),
    .word(rx_word), .full(rx_full)
  );

  dbgx_slot #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .p_load(wr_accept), .p_data(cpu_wr_data[WORD_W-1:0]),
    .p_set(wr_accept), .p_clr(1'b0),
    .d_load(1'b0), .d_data('0),
    .d_set(1'b0), .d_clr(dbg_tx_rd_en),
    .word(tx_word), .full(tx_full)
  );

  dbgx_rdmux #(.W(WORD_W)) u_mux (
    .rd_en(cpu_rd_en), .have_rx(rx_full),
    .tx_word(tx_word), .rx_word(rx_word),
    .rd_data(cpu_rd_data), .rd_empty(cpu_rd_empty)
  );

  assign dbg_tx_rd_data = tx_word;

  // R2: an accepted write fills the transmit mailbox
  a_r2_wr_sets_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !tx_full && !dbg_tx_rd_en) |=> (tx_full && dbg_tx_rd_data == $past(cpu_wr_data[WORD_W-1:0])));
  // R3: a clashing write keeps both words
  a_r3_clash_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_clash |=> $stable(tx_word));
  a_r3_clash_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_clash && !dbg_rx_wr_en) |=> $stable(rx_word));
  // R4: a write leaves the receive flag alone
  a_r4_wr_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !cpu_rd_en && !dbg_rx_wr_en) |=> $stable(rx_full));
  // R7: a read drops the receive flag
  a_r7_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && !dbg_rx_wr_en) |=> !rx_full);
  // R9: a debugger read drops the transmit flag
  a_r9_dbg_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_tx_rd_en |=> !tx_full);
  // R1: reset empties both mailboxes
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!rx_full && !tx_full && dbg_tx_rd_data == '0));
endmodule

// File: tb/sim_dbgx_dtr.sv
`timescale 1ns/1ps
module sim_dbgx_dtr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en, cpu_rd_en, dbg_rx_wr_en, dbg_tx_rd_en;
  logic [63:0] cpu_wr_data, cpu_rd_data;
  logic [31:0] dbg_rx_wr_data, dbg_tx_rd_data;
  logic        cpu_rd_empty, cpu_wr_clash, rx_full, tx_full;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_rx, m_tx;
  logic        m_rxf, m_txf;

  always #2.5 clk = ~clk;

  dbgx_dtr u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, clock, then check state.
  task automatic cyc(input string tag, input logic wr, input logic [63:0] wd,
                     input logic rd, input logic dw, input logic [31:0] dd, input logic dr);
    logic [63:0] exp_rd;
    @(negedge clk);
    cpu_wr_en = wr; cpu_wr_data = wd; cpu_rd_en = rd;
    dbg_rx_wr_en = dw; dbg_rx_wr_data = dd; dbg_tx_rd_en = dr;
    #1;
    exp_rd = (rd && m_rxf) ? {m_tx, m_rx} : 64'h0;
    chk({tag, " rd_data"}, cpu_rd_data, exp_rd);
    chk({tag, " rd_empty"}, {63'h0, cpu_rd_empty}, {63'h0, rd && !m_rxf});
    chk({tag, " clash"}, {63'h0, cpu_wr_clash}, {63'h0, wr && m_txf});
    // reference: processor first, debugger last
    if (wr && !m_txf) begin m_rx = wd[63:32]; m_tx = wd[31:0]; m_txf = 1'b1; end
    if (rd) m_rxf = 1'b0;
    if (dw) begin m_rx = dd; m_rxf = 1'b1; end
    if (dr) m_txf = 1'b0;
    @(posedge clk); #1;
    cpu_wr_en = 0; cpu_rd_en = 0; dbg_rx_wr_en = 0; dbg_tx_rd_en = 0;
    chk({tag, " rx_full"}, {63'h0, rx_full}, {63'h0, m_rxf});
    chk({tag, " tx_full"}, {63'h0, tx_full}, {63'h0, m_txf});
    chk({tag, " tx_word"}, {32'h0, dbg_tx_rd_data}, {32'h0, m_tx});
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
    m_rx = 0; m_tx = 0; m_rxf = 0; m_txf = 0;
    chk("R1 rx_full", {63'h0, rx_full}, 64'h0);
    chk("R1 tx_full", {63'h0, tx_full}, 64'h0);
    chk("R1 tx_word", {32'h0, dbg_tx_rd_data}, 64'h0);
  endtask

  task automatic t_cpu_write();
    cyc("R2", 1, 64'h1111_2222_3333_4444, 0, 0, 0, 0);
    chk("R4 rx_full kept", {63'h0, rx_full}, 64'h0);
  endtask

  task automatic t_empty_read();
    cyc("R6", 0, 0, 1, 0, 0, 0);
    cyc("R6 idle", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_dbg_write_and_read();
    cyc("R8", 0, 0, 0, 1, 32'hA5A5_0F0F, 0);
    cyc("R4 wr keeps rxf", 1, 64'hDEAD_BEEF_0BAD_F00D, 0, 0, 0, 0); // clash, tx full
    cyc("R3 clash", 1, 64'hCAFE_0000_FFFF_0001, 0, 0, 0, 0);
    cyc("R5", 0, 0, 1, 0, 0, 0);
    chk("R7 rx_full cleared", {63'h0, rx_full}, 64'h0);
  endtask

  task automatic t_dbg_drain();
    cyc("R9", 0, 0, 0, 0, 0, 1);
    cyc("R2 again", 1, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0);
    cyc("R8 again", 0, 0, 0, 1, 32'h5555_AAAA, 0);
    cyc("R5 swapped", 0, 0, 1, 0, 0, 0);
    cyc("R9 drain", 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_same_cycle();
    cyc("R10 prep", 0, 0, 0, 1, 32'h1357_9BDF, 0);
    cyc("R10 rd+dbgwr", 0, 0, 1, 1, 32'h2468_ACE0, 0);
    cyc("R10 wr+dbgrd", 1, 64'hFEED_FACE_C0DE_D00D, 0, 0, 0, 1);
    cyc("R10 wr+dbgwr", 1, 64'h7777_7777_8888_8888, 0, 1, 32'h9999_0000, 0);
    cyc("R10 readback", 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; cpu_wr_en = 0; cpu_rd_en = 0; dbg_rx_wr_en = 0; dbg_tx_rd_en = 0;
    cpu_wr_data = 0; dbg_rx_wr_data = 0;
    m_rx = 0; m_tx = 0; m_rxf = 0; m_txf = 0;
    repeat (2) @(posedge clk);
    t_reset();
    t_cpu_write();
    t_empty_read();
    t_dbg_write_and_read();
    t_dbg_drain();
    t_same_cycle();
    cyc("R1 prep", 1, 64'h4242_4242_2424_2424, 0, 1, 32'h6666_6666, 0);
    t_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule